// File: doc/BRIEF.md
# Peak-Valley Hysteretic Boost Switch Controller

This block is the digital core of an inductor boost regulator that keeps the inductor current inside a band by watching it directly. The band is set by two thresholds. When the sampled inductor current falls below the lower (valley) threshold the power switch turns on. When it reaches the upper (peak) threshold the switch turns off. There is no fixed-frequency ramp. The switching rate comes from the inductor, the supply and the width of the band.

Both thresholds are built from one unit current, which is a reference word minus an optional sensor word (for example an ambient-light sensor). The valley sits at half a unit times the mirror ratio K. In remote mode the peak sits at (n + 0.5) units times K, where n is a programmed brightness code. In local mode the code is ignored and the peak is one full unit times K. The thresholds pass through a two-stage registered pipeline. The comparisons against the sampled current are registered before they act on the switch state.

Top module: `hpv_boost_ctrl`

## Requirements
- R1: While reset is asserted, and on the first negative clock edge after it, gate_o is 0 and both threshold outputs are 0.
- R2: The unit current is ref_i minus sens_i. When sens_i is not below ref_i, the unit is 0, both thresholds become 0 and the gate stays off.
- R3: In remote mode (local_mode_i = 0) the peak threshold is unit × (K/2) × (2n+1) and the valley threshold is unit × (K/2), with n = code_i and K = 746. Both appear on the outputs after the second rising edge that follows an input change.
- R4: In local mode (local_mode_i = 1) the peak threshold is unit × K and the valley threshold is unit × (K/2), whatever code_i holds. The switch may run with code_i = 0.
- R5: While running, a sample with isense_i ≥ peak_thr_o turns gate_o off after the second rising edge following that sample (the comparator register, then the switch state).
- R6: While running, a sample with isense_i < valley_thr_o turns gate_o on after the second rising edge. A sample between the two thresholds leaves gate_o unchanged.
- R7: In remote mode, code_i = 0 holds gate_o off.
- R8: When en_i drops, gate_o is still at its old value after the second rising edge and is 0 after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable |
| local_mode_i | input | 1 | 1 = fixed one-unit peak, code ignored |
| code_i | input | CODE_W | Programmed brightness code n |
| ref_i | input | REF_W | Reference current word |
| sens_i | input | REF_W | Sensor current word, subtracted from the reference |
| isense_i | input | THR_W | Sampled inductor current |
| gate_o | output | 1 | Power switch gate, 1 = on |
| peak_thr_o | output | THR_W | Current peak threshold |
| valley_thr_o | output | THR_W | Current valley threshold |

## Verification
An input word change shows on the threshold ports after the second rising edge. A current sample acts on gate_o after the second rising edge, and a change in enable or code forces the gate after the third. The bench keeps a history queue of the input words captured at each rising edge and a behavioural model that applies these delays. It compares all three outputs with the model at every falling edge. Directed checks then pin the exact edge at which the peak trip and the enable drop take effect, by sampling the edge before and the edge after.

// File: rtl/hpv_pkg.sv
package hpv_pkg;
   typedef enum logic {
      SW_OFF = 1'b0,
      SW_ON  = 1'b1
   } sw_state_e;

   localparam int unsigned HPV_DEF_K = 746;
endpackage

// File: rtl/hpv_unit_stage.sv
module hpv_unit_stage #(
   parameter int unsigned REF_W     = 8,
   parameter int unsigned CODE_W    = 3,
   parameter bit          SENSOR_EN = 1'b1,
   localparam int unsigned MULT_W   = CODE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              local_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [REF_W-1:0]  ref_i,
   input  logic [REF_W-1:0]  sens_i,
   output logic [REF_W-1:0]  unit_o,
   output logic [MULT_W-1:0] mult_o,
   output logic              run_o
);
   logic [REF_W-1:0]  unit_d;
   logic [MULT_W-1:0] mult_d;
   logic              run_d;

   generate
      if (SENSOR_EN) begin : g_sub
         assign unit_d = (ref_i > sens_i) ? (ref_i - sens_i) : '0;
      end else begin : g_nosub
         logic unused_sens;
         assign unused_sens = ^sens_i;
         assign unit_d = ref_i;
      end
   endgenerate

   always_comb begin
      if (local_i) mult_d = MULT_W'(2);
      else         mult_d = {code_i, 1'b1};
      run_d = en_i && (unit_d != '0) && (local_i || (code_i != '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unit_o <= '0;
         mult_o <= '0;
         run_o  <= 1'b0;
      end else begin
         unit_o <= unit_d;
         mult_o <= mult_d;
         run_o  <= run_d;
      end
   end
endmodule

// File: rtl/hpv_thresh_stage.sv
module hpv_thresh_stage #(
   parameter int unsigned REF_W  = 8,
   parameter int unsigned CODE_W = 3,
   parameter int unsigned HALF_K = 373,
   parameter int unsigned THR_W  = 21,
   localparam int unsigned MULT_W = CODE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REF_W-1:0]  unit_i,
   input  logic [MULT_W-1:0] mult_i,
   input  logic              run_i,
   output logic [THR_W-1:0]  peak_o,
   output logic [THR_W-1:0]  valley_o,
   output logic              run_o
);
   logic [THR_W-1:0] half_unit;
   logic [THR_W-1:0] peak_d;

   always_comb begin
      half_unit = THR_W'(unit_i) * THR_W'(HALF_K);
      peak_d    = half_unit * THR_W'(mult_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak_o   <= '0;
         valley_o <= '0;
         run_o    <= 1'b0;
      end else begin
         peak_o   <= peak_d;
         valley_o <= half_unit;
         run_o    <= run_i;
      end
   end

   // R3
   thr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valley_o <= peak_o);
endmodule

// File: rtl/hpv_trip_cmp.sv
module hpv_trip_cmp #(
   parameter int unsigned THR_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [THR_W-1:0] isense_i,
   input  logic [THR_W-1:0] peak_i,
   input  logic [THR_W-1:0] valley_i,
   output logic             trip_hi_o,
   output logic             trip_lo_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trip_hi_o <= 1'b0;
         trip_lo_o <= 1'b0;
      end else begin
         trip_hi_o <= (isense_i >= peak_i);
         trip_lo_o <= (isense_i <  valley_i);
      end
   end
endmodule

// File: rtl/hpv_gate_fsm.sv
module hpv_gate_fsm
   import hpv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic trip_hi_i,
   input  logic trip_lo_i,
   output logic gate_o
);
   sw_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!run_i)         st_d = SW_OFF;
      else if (trip_lo_i) st_d = SW_ON;
      else if (trip_hi_i) st_d = SW_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SW_OFF;
      else        st_q <= st_d;
   end

   assign gate_o = (st_q == SW_ON);

   // R8
   gate_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !gate_o);

   // R6
   valley_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && trip_lo_i) |=> gate_o);

   // R5
   peak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && trip_hi_i && !trip_lo_i) |=> !gate_o);
endmodule

// File: rtl/hpv_boost_ctrl.sv
module hpv_boost_ctrl #(
   parameter int unsigned REF_W     = 8,
   parameter int unsigned CODE_W    = 3,
   parameter int unsigned K         = hpv_pkg::HPV_DEF_K,
   parameter bit          SENSOR_EN = 1'b1,
   localparam int unsigned HALF_K   = K / 2,
   localparam int unsigned MULT_W   = CODE_W + 1,
   localparam int unsigned THR_W    = REF_W + $clog2(HALF_K + 1) + MULT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              local_mode_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [REF_W-1:0]  ref_i,
   input  logic [REF_W-1:0]  sens_i,
   input  logic [THR_W-1:0]  isense_i,
   output logic              gate_o,
   output logic [THR_W-1:0]  peak_thr_o,
   output logic [THR_W-1:0]  valley_thr_o
);
   generate
      if ((K % 2) != 0 || K < 2) begin : g_bad_k
         $error("hpv_boost_ctrl: K must be even and at least 2");
      end
      if (REF_W < 1 || CODE_W < 1) begin : g_bad_w
         $error("hpv_boost_ctrl: widths must be positive");
      end
   endgenerate

   logic [REF_W-1:0]  unit_s1;
   logic [MULT_W-1:0] mult_s1;
   logic              run_s1;
   logic              run_s2;
   logic              trip_hi, trip_lo;

   hpv_unit_stage #(
      .REF_W(REF_W), .CODE_W(CODE_W), .SENSOR_EN(SENSOR_EN)
   ) u_unit (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .local_i(local_mode_i),
      .code_i(code_i), .ref_i(ref_i), .sens_i(sens_i),
      .unit_o(unit_s1), .mult_o(mult_s1), .run_o(run_s1)
   );

   hpv_thresh_stage #(
      .REF_W(REF_W), .CODE_W(CODE_W), .HALF_K(HALF_K), .THR_W(THR_W)
   ) u_thr (
      .clk(clk), .rst_n(rst_n), .unit_i(unit_s1), .mult_i(mult_s1),
      .run_i(run_s1), .peak_o(peak_thr_o), .valley_o(valley_thr_o),
      .run_o(run_s2)
   );

   hpv_trip_cmp #(.THR_W(THR_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .isense_i(isense_i),
      .peak_i(peak_thr_o), .valley_i(valley_thr_o),
      .trip_hi_o(trip_hi), .trip_lo_o(trip_lo)
   );

   hpv_gate_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .run_i(run_s2),
      .trip_hi_i(trip_hi), .trip_lo_i(trip_lo), .gate_o(gate_o)
   );

   // R2
   zero_unit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valley_thr_o == '0) |=> !gate_o);
endmodule

// File: tb/hpv_boost_ctrl_tb_top.sv
module hpv_boost_ctrl_tb_top;
   localparam int REF_W  = 8;
   localparam int CODE_W = 3;
   localparam int KV     = 746;
   localparam int THR_W  = 21;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en_i = 1'b0;
   logic              local_mode_i = 1'b0;
   logic [CODE_W-1:0] code_i = '0;
   logic [REF_W-1:0]  ref_i = '0;
   logic [REF_W-1:0]  sens_i = '0;
   logic [THR_W-1:0]  isense_i = '0;
   logic              gate_o;
   logic [THR_W-1:0]  peak_thr_o, valley_thr_o;

   always #5 clk = ~clk;

   hpv_boost_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .local_mode_i(local_mode_i),
      .code_i(code_i), .ref_i(ref_i), .sens_i(sens_i), .isense_i(isense_i),
      .gate_o(gate_o), .peak_thr_o(peak_thr_o), .valley_thr_o(valley_thr_o)
   );

   typedef struct {
      int en, loc, code, rf, sn;
   } xin_t;

   xin_t hist[$];
   int   m_peak, m_valley, m_run, m_thi, m_tlo, m_gate;
   int   n_vec = 0, n_bad = 0;
   bit   cmp_on = 1'b0, done = 1'b0;
   string cur_tag = "R1";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist.delete();
         m_peak = 0; m_valley = 0; m_run = 0;
         m_thi = 0; m_tlo = 0; m_gate = 0;
      end else begin
         xin_t cur;
         if (m_run == 0)       m_gate = 0;
         else if (m_tlo != 0)  m_gate = 1;
         else if (m_thi != 0)  m_gate = 0;
         m_thi = (int'(isense_i) >= m_peak) ? 1 : 0;
         m_tlo = (int'(isense_i) <  m_valley) ? 1 : 0;
         if (hist.size() > 0) begin
            xin_t p;
            int u;
            p = hist.pop_front();
            u = (p.rf > p.sn) ? p.rf - p.sn : 0;
            m_valley = u * KV / 2;
            m_peak   = (p.loc != 0) ? u * KV : u * KV * (2 * p.code + 1) / 2;
            m_run    = (p.en != 0 && u > 0 && (p.loc != 0 || p.code != 0)) ? 1 : 0;
         end
         cur.en = int'(en_i); cur.loc = int'(local_mode_i);
         cur.code = int'(code_i); cur.rf = int'(ref_i); cur.sn = int'(sens_i);
         hist.push_back(cur);
      end
   end

   task automatic check(input string tag, input int act, input int exp_v, input string what);
      n_vec++;
      if (act != exp_v) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp_v, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         check(cur_tag, int'(gate_o), m_gate, "model gate");
         check(cur_tag, int'(peak_thr_o), m_peak, "model peak");
         check(cur_tag, int'(valley_thr_o), m_valley, "model valley");
      end
   end

   task automatic drive(input int en, input int loc, input int code,
                        input int rf, input int sn, input int isn);
      #1;
      en_i = en[0]; local_mode_i = loc[0]; code_i = CODE_W'(code);
      ref_i = REF_W'(rf); sens_i = REF_W'(sn); isense_i = THR_W'(isn);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      // R1 reset state
      check("R1", int'(gate_o), 0, "gate in reset");
      check("R1", int'(peak_thr_o), 0, "peak in reset");
      check("R1", int'(valley_thr_o), 0, "valley in reset");
      #1 rst_n = 1'b1;
      cyc(1);
      check("R1", int'(gate_o), 0, "gate after reset");
      check("R1", int'(peak_thr_o), 0, "peak after reset");
      cmp_on = 1'b1;

      // R3 remote thresholds, n = 3
      cur_tag = "R3";
      drive(1, 0, 3, 10, 0, 0);
      cyc(1);
      check("R3", int'(peak_thr_o), 0, "peak one edge after change");
      cyc(1);
      check("R3", int'(peak_thr_o), 26110, "peak n=3");
      check("R3", int'(valley_thr_o), 3730, "valley n=3");
      cur_tag = "R6";
      cyc(2);
      check("R6", int'(gate_o), 1, "gate on below valley");
      drive(1, 0, 3, 10, 0, 10000);
      cyc(4);
      check("R6", int'(gate_o), 1, "gate holds in band");
      // R5 exact peak trip latency
      cur_tag = "R5";
      drive(1, 0, 3, 10, 0, 30000);
      cyc(1);
      check("R5", int'(gate_o), 1, "gate one edge after peak sample");
      cyc(1);
      check("R5", int'(gate_o), 0, "gate two edges after peak sample");
      cur_tag = "R6";
      drive(1, 0, 3, 10, 0, 10000);
      cyc(3);
      check("R6", int'(gate_o), 0, "gate stays off in band");
      drive(1, 0, 3, 10, 0, 100);
      cyc(3);
      check("R6", int'(gate_o), 1, "gate back on below valley");

      // R2 sensor subtraction and saturation
      cur_tag = "R2";
      drive(1, 0, 1, 20, 5, 100);
      cyc(2);
      check("R2", int'(peak_thr_o), 16785, "peak with sensor");
      check("R2", int'(valley_thr_o), 5595, "valley with sensor");
      drive(1, 0, 1, 20, 30, 0);
      cyc(4);
      check("R2", int'(peak_thr_o), 0, "peak saturated");
      check("R2", int'(valley_thr_o), 0, "valley saturated");
      check("R2", int'(gate_o), 0, "gate off saturated");

      // R7 remote code zero
      cur_tag = "R7";
      drive(1, 0, 0, 10, 0, 0);
      cyc(4);
      check("R7", int'(gate_o), 0, "gate off code zero");
      check("R7", int'(peak_thr_o), 3730, "peak code zero");

      // R4 local mode
      cur_tag = "R4";
      drive(1, 1, 0, 10, 0, 0);
      cyc(4);
      check("R4", int'(peak_thr_o), 7460, "local peak");
      check("R4", int'(valley_thr_o), 3730, "local valley");
      check("R4", int'(gate_o), 1, "local gate on with code zero");
      drive(1, 1, 5, 10, 0, 0);
      cyc(3);
      check("R4", int'(peak_thr_o), 7460, "local peak ignores code");

      // R8 enable drop latency
      cur_tag = "R8";
      drive(0, 1, 5, 10, 0, 0);
      cyc(2);
      check("R8", int'(gate_o), 1, "gate two edges after enable drop");
      cyc(1);
      check("R8", int'(gate_o), 0, "gate three edges after enable drop");

      // R3 full-scale boundary
      cur_tag = "R3";
      drive(1, 0, 7, 255, 0, 0);
      cyc(2);
      check("R3", int'(peak_thr_o), 1426725, "peak full scale");
      check("R3", int'(valley_thr_o), 95115, "valley full scale");
      cyc(3);
      check("R3", int'(gate_o), 1, "gate on full scale");

      cyc(2);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule